// File: doc/BRIEF.md
# SPI memory slave hold controller

The block is the serial front end of an SPI memory slave that can be paused. A host selects it with an active-low chip select and clocks in command bytes in SPI mode 0. Input data is sampled on the rising serial clock edge, most significant bit first. Output data changes on the falling edge. The block keeps a write-enable latch and a busy flag. Both are visible through a status read. A stand-in chip-erase command starts an internally timed operation that runs for a fixed number of system clock cycles.

An active-low pause input lets the host stop a transfer without stopping the serial clock. While paused, the serial clock and data input are ignored and the output driver is off. The pause starts and ends only during a clock-low phase; a request that arrives while the clock is high waits for the next low phase. If chip select is released while the pause is still active, the command is aborted and the write-enable latch is cleared. The pause never stalls the internal timed operation. The write-protect input stays effective throughout.

All pins are resynchronised into the system clock domain and oversampled, so the serial clock must stay well below the system clock rate. The serial output is given as a data bit plus an output-enable, for a tri-state pad outside the block.

Top module: `spi_hold_front`

## Requirements
- R1: Mode 0 command bytes, sampled on rising serial clock edges MSB first, execute when their 8th bit is sampled; only the first byte after chip select falls is a command. Opcode 0x06 sets the write-enable latch and 0x04 clears it. Any other opcode except 0x05 and 0x60 has no effect.
- R2: Opcode 0x05 makes the block drive a status byte MSB first, each bit changing on a falling edge, starting with the falling edge after the 8th command bit. The byte is refreshed and repeated every 8 bits. Status bit 0 is busy, bit 1 is write-enable, bit 7 is the write-protect input level (1 = not protected), and bits 6..2 read 0.
- R3: The output enable is low out of reset, while chip select is high, during a pause, and at all times except the data phase of a status read.
- R4: A pause begins only while chip select is low. Pulling the pause input low during a clock-low phase pauses at once. Pulling it low during a clock-high phase pauses only when the clock next goes low.
- R5: During a pause, serial clock edges and data input bits are ignored: the received command bits and the transmitted status bits resume exactly where they stopped.
- R6: A pause ends only in a clock-low phase with the pause input high. If the pause input goes high during a clock-high phase, the block stays paused until the clock next goes low, and that falling edge is ignored.
- R7: Raising chip select while paused aborts the command and clears the write-enable latch. Raising it after the pause has ended leaves the latch unchanged.
- R8: Opcode 0x60 is accepted only when write-enable is 1 and write-protect is high. It then holds busy at 1 for ERASE_CYCLES system clock cycles, after which busy and write-enable both return to 0. If it is rejected, it has no effect.
- R9: The busy countdown continues unchanged during a pause.
- R10: Write-protect changes made during a pause take effect at once, for the erase guard and for status bit 7.
- R11: While busy, opcodes 0x06, 0x04 and 0x60 are ignored; status reads still work.
- R12: Raising chip select discards a partly received byte and resets bit counting, so the next selection starts a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idles low (mode 0) |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| wp_ni | input | 1 | Write protect, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data out pad |

## Verification
On every cycle, the embedded properties check several things. A pause can only start with chip select low and in a low clock phase, and it can only end in a low phase or through deselection. Bit and output counters stay frozen while paused. The busy countdown decrements by one each cycle. An accepted erase always follows a set latch with protection off, an abort always clears the latch, and the latch does not move while busy. Only the bench scenarios can show the full effect at the pins: a deferred entry keeps the output on until the clock falls, a deferred exit keeps it off until the clock falls, a status byte read across a pause arrives intact, deselection inside a pause differs from deselection after it, and a protect change made during a pause blocks a later erase.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_WEL_SET = 8'h06;
  localparam byte_t OP_WEL_CLR = 8'h04;
  localparam byte_t OP_STATUS  = 8'h05;
  localparam byte_t OP_ERASE   = 8'h60;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_WP   = 7;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_phase.sv
module spi_hold_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic hold_o,
  output logic abort_o,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;
  logic hold_q;
  logic live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      if (cs_n_i)      hold_q <= 1'b0;
      else if (!sck_i) hold_q <= !hold_n_i;  // pause state moves only in a low phase
    end
  end

  assign live    = !cs_n_i && !hold_q;
  assign rise_o  = live && sck_i && !sck_q;
  assign fall_o  = live && !sck_i && sck_q;
  assign abort_o = cs_n_i && hold_q;
  assign hold_o  = hold_q;

  p_hold_needs_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !hold_q);

  p_hold_enter_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> $past(!sck_i && !hold_n_i && !cs_n_i));

  p_hold_exit_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(cs_n_i || (!sck_i && hold_n_i)));
endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter
  import spi_hold_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_n_i,
  input  logic  hold_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  si_i,
  input  byte_t status_i,
  output logic  op_valid_o,
  output byte_t op_o,
  output logic  so_o,
  output logic  so_oe_o
);
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_q;
  logic       cmd_done_q;
  logic       rd_mode_q;
  logic       tx_on_q;
  logic [2:0] tx_cnt_q;
  logic [6:0] tx_sr_q;
  logic       so_q;

  assign op_o       = {rx_q, si_i};
  assign op_valid_o = rise_i && (bit_cnt_q == 3'd7) && !cmd_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      cmd_done_q <= 1'b0;
      rd_mode_q  <= 1'b0;
      tx_on_q    <= 1'b0;
      tx_cnt_q   <= '0;
      tx_sr_q    <= '0;
      so_q       <= 1'b0;
    end else if (cs_n_i) begin
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      cmd_done_q <= 1'b0;
      rd_mode_q  <= 1'b0;
      tx_on_q    <= 1'b0;
      tx_cnt_q   <= '0;
      so_q       <= 1'b0;
    end else begin
      if (rise_i) begin
        rx_q      <= {rx_q[5:0], si_i};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (op_valid_o) begin
          cmd_done_q <= 1'b1;
          rd_mode_q  <= (op_o == OP_STATUS);
        end
      end
      if (fall_i && rd_mode_q) begin
        tx_on_q  <= 1'b1;
        tx_cnt_q <= tx_cnt_q + 3'd1;
        if (tx_cnt_q == 3'd0) begin  // fresh status snapshot each byte
          so_q    <= status_i[7];
          tx_sr_q <= status_i[6:0];
        end else begin
          so_q    <= tx_sr_q[6];
          tx_sr_q <= {tx_sr_q[5:0], 1'b0};
        end
      end
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = tx_on_q && !cs_n_i && !hold_i;

  p_cnt_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cs_n_i) |=> ($stable(bit_cnt_q) && $stable(tx_cnt_q) && $stable(so_q)));

  p_cnt_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (bit_cnt_q == 3'd0 && !tx_on_q));
endmodule

// File: rtl/spi_hold_cmd.sv
module spi_hold_cmd
  import spi_hold_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 200
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  op_valid_i,
  input  byte_t op_i,
  input  logic  abort_i,
  input  logic  wp_n_i,
  output byte_t status_o
);
  localparam int unsigned CW = $clog2(ERASE_CYCLES + 1);

  logic          wel_q;
  logic [CW-1:0] busy_cnt_q;
  logic          busy;

  assign busy = (busy_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q      <= 1'b0;
      busy_cnt_q <= '0;
    end else begin
      if (busy) begin
        busy_cnt_q <= busy_cnt_q - CW'(1);
        if (busy_cnt_q == CW'(1)) wel_q <= 1'b0;
      end
      if (abort_i) begin
        wel_q <= 1'b0;
      end else if (op_valid_i && !busy) begin
        unique case (op_i)
          OP_WEL_SET: wel_q <= 1'b1;
          OP_WEL_CLR: wel_q <= 1'b0;
          OP_ERASE: if (wel_q && wp_n_i) busy_cnt_q <= CW'(ERASE_CYCLES);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = busy;
    status_o[ST_WEL]  = wel_q;
    status_o[ST_WP]   = wp_n_i;
  end

  p_busy_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (busy_cnt_q == $past(busy_cnt_q) - CW'(1)));

  p_erase_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel_q && wp_n_i));

  p_abort_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !wel_q);

  p_busy_lock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && busy_cnt_q != CW'(1) && !abort_i) |=> (wel_q == $past(wel_q)));
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
  import spi_hold_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 200,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic so_o,
  output logic so_oe_o
);
  localparam int unsigned NPINS = 5;

  logic [NPINS-1:0] pins_s;
  logic  cs_n_s, sck_s, si_s, hold_n_s, wp_n_s;
  logic  hold, abort, rise, fall;
  logic  op_valid;
  byte_t op;
  byte_t status;

  spi_hold_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(5'b10011)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i, hold_ni, wp_ni}),
    .q_o   (pins_s)
  );

  assign {cs_n_s, sck_s, si_s, hold_n_s, wp_n_s} = pins_s;

  spi_hold_phase i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (cs_n_s),
    .sck_i   (sck_s),
    .hold_n_i(hold_n_s),
    .hold_o  (hold),
    .abort_o (abort),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  spi_hold_shifter i_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_n_s),
    .hold_i    (hold),
    .rise_i    (rise),
    .fall_i    (fall),
    .si_i      (si_s),
    .status_i  (status),
    .op_valid_o(op_valid),
    .op_o      (op),
    .so_o      (so_o),
    .so_oe_o   (so_oe_o)
  );

  spi_hold_cmd #(
    .ERASE_CYCLES(ERASE_CYCLES)
  ) i_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_valid_i(op_valid),
    .op_i      (op),
    .abort_i   (abort),
    .wp_n_i    (wp_n_s),
    .status_o  (status)
  );

  p_oe_needs_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (!hold && !cs_n_s));
endmodule

// File: tb/test_spi_hold_front.sv
module test_spi_hold_front;
  import spi_hold_pkg::*;

  localparam int unsigned ERASE = 1000;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit wel_m = 1'b0;

  always #2.5 clk = ~clk;

  spi_hold_front #(.ERASE_CYCLES(ERASE), .SYNC_STAGES(2)) i_spi_hold_front (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .wp_ni(wp_n), .so_o(so), .so_oe_o(so_oe)
  );

  function automatic byte_t exp_st(bit wp, bit wel, bit busy);
    return {wp, 5'b00000, wel, busy};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wt(HALF);
  endtask

  task automatic cs_end();
    wt(HALF);
    cs_n = 1'b1;
    wt(2*HALF);
  endtask

  task automatic xfer(input bit b, output bit o, output bit oe);
    si = b;
    wt(HALF);
    o  = so;
    oe = so_oe;
    sck = 1'b1;
    wt(HALF);
    sck = 1'b0;
  endtask

  task automatic hold_episode(input bit chk_oe);
    hold_n = 1'b0;
    wt(HALF);
    if (chk_oe) chk(so_oe == 1'b0, "R3 oe off in pause", so_oe, 0);
    for (int g = 0; g < 3; g++) begin
      si = 1'($urandom);
      sck = 1'b1;
      wt(HALF);
      sck = 1'b0;
      wt(HALF);
    end
    hold_n = 1'b1;
    wt(HALF);
  endtask

  task automatic send_bits(input byte_t v, input int hpos);
    bit o, oe;
    for (int i = 7; i >= 0; i--) begin
      if (i == hpos) hold_episode(1'b0);
      xfer(v[i], o, oe);
      chk(oe == 1'b0, "R3 oe off in command", oe, 0);
    end
  endtask

  task automatic send_cmd(input byte_t v, input int hpos);
    cs_begin();
    send_bits(v, hpos);
    cs_end();
  endtask

  task automatic rd_status(output byte_t s, input int hpos);
    bit o, oe;
    cs_begin();
    send_bits(OP_STATUS, -1);
    for (int i = 7; i >= 0; i--) begin
      if (i == hpos) hold_episode(1'b1);
      xfer(1'b0, o, oe);
      s[i] = o;
      chk(oe == 1'b1, "R2 oe on in read", oe, 1);
    end
    cs_end();
  endtask

  initial begin
    byte_t s;
    byte_t op;
    bit o, oe;
    void'($urandom(32'h5EED_0042));
    wt(5);
    chk(so_oe == 1'b0, "R3 reset oe", so_oe, 0);
    rst_n = 1'b1;
    wt(4);
    chk(so_oe == 1'b0, "R3 idle oe", so_oe, 0);

    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R2 reset status", s, exp_st(1, 0, 0));
    send_cmd(OP_WEL_SET, -1);
    rd_status(s, -1);
    chk(s == exp_st(1, 1, 0), "R1 set latch", s, exp_st(1, 1, 0));
    send_cmd(OP_WEL_CLR, -1);
    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R1 clear latch", s, exp_st(1, 0, 0));

    // R12: partial byte then deselect
    cs_begin();
    for (int i = 0; i < 4; i++) xfer(1'b0, o, oe);
    cs_end();
    send_cmd(OP_WEL_SET, -1);
    rd_status(s, -1);
    chk(s == exp_st(1, 1, 0), "R12 fresh command", s, exp_st(1, 1, 0));

    // R5: pause with clock activity inside a command byte
    send_cmd(OP_WEL_CLR, 3);
    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R5 command across pause", s, exp_st(1, 0, 0));

    // R5: pause inside the status data phase
    send_cmd(OP_WEL_SET, -1);
    rd_status(s, 4);
    chk(s == exp_st(1, 1, 0), "R5 read across pause", s, exp_st(1, 1, 0));

    // R2: status repeats every byte
    cs_begin();
    send_bits(OP_STATUS, -1);
    for (int i = 15; i >= 0; i--) begin
      xfer(1'b0, o, oe);
      if (i < 8) s[i] = o;
    end
    cs_end();
    chk(s == exp_st(1, 1, 0), "R2 repeated byte", s, exp_st(1, 1, 0));

    // R4 / R6: deferred entry and deferred exit (status 0x82)
    cs_begin();
    send_bits(OP_STATUS, -1);
    for (int i = 7; i >= 5; i--) begin
      xfer(1'b0, o, oe);
      chk(o == exp_st(1, 1, 0)[i], "R2 status bit", o, exp_st(1, 1, 0)[i]);
    end
    si = 1'b0;
    wt(HALF);
    chk(so == exp_st(1, 1, 0)[4], "R2 status bit4", so, exp_st(1, 1, 0)[4]);
    sck = 1'b1;
    wt(2);
    hold_n = 1'b0;
    wt(HALF);
    chk(so_oe == 1'b1, "R4 deferred entry", so_oe, 1);
    sck = 1'b0;
    wt(HALF);
    chk(so_oe == 1'b0, "R4 entry at low", so_oe, 0);
    for (int g = 0; g < 2; g++) begin
      sck = 1'b1; wt(HALF); sck = 1'b0; wt(HALF);
    end
    sck = 1'b1;
    wt(2);
    hold_n = 1'b1;
    wt(HALF);
    chk(so_oe == 1'b0, "R6 deferred exit", so_oe, 0);
    sck = 1'b0;
    wt(HALF);
    chk(so_oe == 1'b1, "R6 exit at low", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin
      xfer(1'b0, o, oe);
      chk(o == exp_st(1, 1, 0)[i], "R6 bit after exit", o, exp_st(1, 1, 0)[i]);
    end
    cs_end();

    // R7: deselect during pause aborts and clears latch
    cs_begin();
    send_bits(OP_WEL_SET, -1);
    hold_n = 1'b0;
    wt(HALF);
    cs_n = 1'b1;
    wt(2*HALF);
    hold_n = 1'b1;
    wt(HALF);
    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R7 abort clears latch", s, exp_st(1, 0, 0));
    // R7 control: pause ends before deselect
    send_cmd(OP_WEL_SET, -1);
    cs_begin();
    hold_episode(1'b0);
    cs_end();
    rd_status(s, -1);
    chk(s == exp_st(1, 1, 0), "R7 no abort after resume", s, exp_st(1, 1, 0));

    // R8: erase rejected without latch
    send_cmd(OP_WEL_CLR, -1);
    send_cmd(OP_ERASE, -1);
    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R8 erase rejected", s, exp_st(1, 0, 0));

    // R8 / R11: accepted erase, commands ignored while busy
    send_cmd(OP_WEL_SET, -1);
    send_cmd(OP_ERASE, -1);
    rd_status(s, -1);
    chk(s == exp_st(1, 1, 1), "R8 busy after erase", s, exp_st(1, 1, 1));
    send_cmd(OP_WEL_CLR, -1);
    rd_status(s, -1);
    chk(s == exp_st(1, 1, 1), "R11 clear ignored while busy", s, exp_st(1, 1, 1));
    wt(ERASE + 200);
    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R8 erase done", s, exp_st(1, 0, 0));

    // R9: countdown runs during a long pause
    send_cmd(OP_WEL_SET, -1);
    send_cmd(OP_ERASE, -1);
    cs_begin();
    hold_n = 1'b0;
    wt(ERASE + 200);
    hold_n = 1'b1;
    cs_end();
    rd_status(s, -1);
    chk(s == exp_st(1, 0, 0), "R9 erase finished in pause", s, exp_st(1, 0, 0));

    // R10: protect changed inside pause blocks erase
    send_cmd(OP_WEL_SET, -1);
    cs_begin();
    hold_n = 1'b0;
    wt(HALF);
    wp_n = 1'b0;
    wt(HALF);
    hold_n = 1'b1;
    wt(HALF);
    send_bits(OP_ERASE, -1);
    cs_end();
    rd_status(s, -1);
    chk(s == exp_st(0, 1, 0), "R10 protect blocks erase", s, exp_st(0, 1, 0));
    wp_n = 1'b1;
    send_cmd(OP_WEL_CLR, -1);
    wel_m = 1'b0;

    // random command mix with random pauses
    for (int it = 0; it < 30; it++) begin
      int unsigned sel;
      int hpos;
      sel = $urandom_range(0, 3);
      hpos = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 7)) : -1;
      case (sel)
        0: op = OP_WEL_SET;
        1: op = OP_WEL_CLR;
        2: op = OP_STATUS;
        default: begin
          op = byte_t'($urandom);
          while (op == OP_STATUS || op == OP_WEL_SET || op == OP_WEL_CLR || op == OP_ERASE)
            op = byte_t'($urandom);
        end
      endcase
      if (op == OP_WEL_SET) wel_m = 1'b1;
      if (op == OP_WEL_CLR) wel_m = 1'b0;
      send_cmd(op, hpos);
      rd_status(s, ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 7)) : -1);
      chk(s == exp_st(1, wel_m, 0), "R1 R5 random mix", s, exp_st(1, wel_m, 0));
    end

    summary();
    $finish;
  end
endmodule